// File: doc/BRIEF.md
# Nonvolatile Page Erase and Program Controller

This block sits between a serial-bus command decoder and a 1 KiB nonvolatile byte array. The array is mapped at 0xF800 to 0xFBFF and split into 32-byte pages. The decoder hands over one request per cycle: a byte read, a byte program or a page erase.

The controller enforces the usual rules of such a memory:
- A byte can be programmed only while it is blank (0xFF).
- A page returns to blank only through an erase of the whole page.
- An erase happens only while the erase-enable input is high.

Program and erase each take a fixed number of clock cycles, set by parameters. During that time the controller reports `busy`, and the bus side answers any access with a NACK. While a byte is being programmed, `stretch` also asks the bus engine to hold the serial clock low.

A block write is a run of byte-program requests at increasing addresses. It may cross a page boundary freely. Any request outside the mapped window is discarded, including bytes of a block that would run past 0xFBFF.

Top module: `nvm_page_ctrl`

## Requirements
- R1: After reset, `busy`, `stretch`, `rd_valid` and `wr_err` are low, and every byte of the array reads 0xFF.
- R2: A read request (`req_op`=00) to a mapped address, accepted while `busy` is low, produces `rd_valid` high with that byte on `rd_data` in the next cycle only.
- R3: A program request (`req_op`=01) to a blank byte drives `busy` and `stretch` high for exactly PROG_CYC cycles, starting the cycle after acceptance. The byte holds the new value once `busy` falls.
- R4: A program request to a byte that is not 0xFF leaves the byte unchanged and starts no busy period. It sets `wr_err` from the next cycle, and `wr_err` stays set until reset.
- R5: An erase request (`req_op`=10) with `erase_en` high drives `busy` high, with `stretch` low, for exactly ERASE_CYC cycles. It then sets all 32 bytes of the page to 0xFF. The page is given by address bits 9:5; bits 4:0 are ignored. Erased bytes can be programmed again.
- R6: An erase request with `erase_en` low has no effect: no busy period and no change to the array.
- R7: A request whose address is outside 0xF800 to 0xFBFF is discarded: no busy period, no `rd_valid`, no change to the array. `req_op`=11 is likewise discarded.
- R8: Any request presented while `busy` is high is ignored.
- R9: Back-to-back program requests at consecutive addresses across a page boundary all complete, with no page restriction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 read, 01 program, 10 erase, 11 discarded |
| req_addr | input | 16 | Full byte address |
| req_data | input | 8 | Program data |
| erase_en | input | 1 | Permits page erase when high |
| busy | output | 1 | Operation in progress; the bus side answers with a NACK |
| stretch | output | 1 | Clock-stretch request during byte program |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| wr_err | output | 1 | Sticky flag: a program was attempted on a non-blank byte |

## Verification
Read data and the error flag are due one cycle after the accepting edge. `busy` rises in that same cycle, stays up for PROG_CYC or ERASE_CYC cycles, and the array contents change at the edge where it falls.

The bench drives inputs on the falling edge and runs a behavioural model on the rising edge. It compares every output at the next falling edge, so each result is checked in exactly the cycle it is due. Directed reads after each operation confirm the contents of the array.

// File: rtl/nvm_page_ctrl.sv
module nvm_page_ctrl #(
  parameter logic [15:0] BASE      = 16'hF800,
  parameter int          ADDR_W    = 10,
  parameter int          PAGE_W    = 5,
  parameter int          PROG_CYC  = 31250,
  parameter int          ERASE_CYC = 2500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_op,
  input  logic [15:0] req_addr,
  input  logic [7:0] req_data,
  input  logic       erase_en,
  output logic       busy,
  output logic       stretch,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       wr_err
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [7:0]        mem [DEPTH];
  logic [CNT_W-1:0]  cnt;
  logic              is_prog;
  logic [ADDR_W-1:0] tgt;
  logic [7:0]        tgt_dat;

  wire              hit   = req_addr[15:ADDR_W] == BASE[15:ADDR_W];
  wire [ADDR_W-1:0] off   = req_addr[ADDR_W-1:0];
  wire              take  = req_valid && !busy && hit;
  wire              blank = mem[off] == 8'hFF;
  wire              go_rd = take && req_op == 2'b00;
  wire              go_pg = take && req_op == 2'b01 && blank;
  wire              go_er = take && req_op == 2'b10 && erase_en;
  wire              bad   = take && req_op == 2'b01 && !blank;
  wire              done  = busy && cnt == CNT_W'(1);

  assign stretch = busy && is_prog;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      is_prog  <= 1'b0;
      cnt      <= '0;
      tgt      <= '0;
      tgt_dat  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      wr_err   <= 1'b0;
    end else begin
      rd_valid <= go_rd;
      if (go_rd) rd_data <= mem[off];
      if (bad) wr_err <= 1'b1;
      if (go_pg || go_er) begin
        busy    <= 1'b1;
        is_prog <= go_pg;
        cnt     <= go_pg ? CNT_W'(PROG_CYC) : CNT_W'(ERASE_CYC);
        tgt     <= off;
        tgt_dat <= req_data;
      end else if (done) begin
        busy    <= 1'b0;
        is_prog <= 1'b0;
        cnt     <= '0;
      end else if (busy) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (done) begin
      if (is_prog) begin
        mem[tgt] <= tgt_dat;
      end else begin
        for (int i = 0; i < DEPTH; i++)
          if ((i >> PAGE_W) == (int'(tgt) >> PAGE_W)) mem[i] <= 8'hFF;
      end
    end
  end
endmodule

// File: rtl/nvm_page_ctrl_chk.sv
module nvm_page_ctrl_chk #(
  parameter logic [15:0] BASE   = 16'hF800,
  parameter int          ADDR_W = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_op,
  input logic [15:0] req_addr,
  input logic        erase_en,
  input logic        busy,
  input logic        stretch,
  input logic        rd_valid,
  input logic        wr_err
);
  wire in_win = req_addr[15:ADDR_W] == BASE[15:ADDR_W];
  wire idle_req = req_valid && !busy;

  AST_STRETCH_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) stretch |-> busy); // R3
  AST_RD_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> $past(idle_req && req_op == 2'b00)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) wr_err |=> wr_err); // R4
  AST_NO_RD_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !rd_valid); // R8
  AST_OOR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) (idle_req && !in_win) |=> (!busy && !rd_valid)); // R7
  AST_ERASE_GATED: assert property (@(posedge clk) disable iff (!rst_n) (idle_req && req_op == 2'b10 && !erase_en) |=> !busy); // R6
  AST_PROG_REACTS: assert property (@(posedge clk) disable iff (!rst_n) (idle_req && in_win && req_op == 2'b01) |=> (busy || wr_err)); // R3
endmodule

bind nvm_page_ctrl nvm_page_ctrl_chk #(.BASE(BASE), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/nvm_page_ctrl_tb.sv
module nvm_page_ctrl_tb_top;
  localparam int PROG = 6;
  localparam int ERAS = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [15:0] req_addr = 16'h0;
  logic [7:0] req_data = 8'h0;
  logic erase_en = 1'b0;
  logic busy, stretch, rd_valid, wr_err;
  logic [7:0] rd_data;

  int errors = 0;
  int checks = 0;
  bit mon_on = 1'b0;

  always #4 clk = ~clk;

  nvm_page_ctrl #(.PROG_CYC(PROG), .ERASE_CYC(ERAS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .erase_en(erase_en),
    .busy(busy), .stretch(stretch), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_err(wr_err));

  // behavioural reference
  int m_mem [1024];
  int m_left, m_kind, m_off, m_dat, e_rd;
  bit e_rdv, e_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 255;
      m_left = 0; m_kind = 0; e_rdv = 0; e_err = 0; e_rd = 0;
    end else begin
      e_rdv = 0;
      if (m_left > 0) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          if (m_kind == 1) m_mem[m_off] = m_dat;
          else for (int k = 0; k < 32; k++) m_mem[(m_off / 32) * 32 + k] = 255;
        end
      end else if (req_valid && req_addr >= 16'hF800 && req_addr <= 16'hFBFF) begin
        int o;
        o = int'(req_addr) - 'hF800;
        if (req_op == 2'b00) begin e_rdv = 1; e_rd = m_mem[o]; end
        else if (req_op == 2'b01) begin
          if (m_mem[o] == 255) begin m_left = PROG; m_kind = 1; m_off = o; m_dat = req_data; end
          else e_err = 1;
        end else if (req_op == 2'b10 && erase_en) begin
          m_left = ERAS; m_kind = 2; m_off = o;
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    chk("R3 busy", busy, m_left > 0);
    chk("R3 stretch", stretch, (m_left > 0) && (m_kind == 1));
    chk("R2 rd_valid", rd_valid, e_rdv);
    if (e_rdv) chk("R2 rd_data", rd_data, e_rd);
    chk("R4 wr_err", wr_err, e_err);
  end

  task automatic req(logic [1:0] op, logic [15:0] a, logic [7:0] d);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd_exp(logic [15:0] a, int exp, string tag);
    req(2'b00, a, 8'h00);
    chk(tag, rd_valid, 1);
    chk(tag, rd_data, exp);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;
    chk("R1 busy", busy, 0); chk("R1 stretch", stretch, 0);
    chk("R1 rd_valid", rd_valid, 0); chk("R1 wr_err", wr_err, 0);
    rd_exp(16'hF800, 'hFF, "R1 blank low");
    rd_exp(16'hFBFF, 'hFF, "R1 blank high");

    // R3 program blank byte, count busy cycles
    req(2'b01, 16'hF805, 8'h3C);
    begin
      int n = 0;
      while (busy) begin chk("R3 stretch", stretch, 1); n++; @(negedge clk); end
      chk("R3 cycles", n, PROG);
    end
    rd_exp(16'hF805, 'h3C, "R3 value");

    // R4 non-blank
    req(2'b01, 16'hF805, 8'h00);
    chk("R4 no busy", busy, 0); chk("R4 flag", wr_err, 1);
    rd_exp(16'hF805, 'h3C, "R4 unchanged");

    // R9 across page boundary
    for (int i = 0; i < 4; i++) begin
      req(2'b01, 16'hF81E + 16'(i), 8'h10 + 8'(i));
      settle();
    end
    for (int i = 0; i < 4; i++) rd_exp(16'hF81E + 16'(i), 'h10 + i, "R9 block");

    // R8 request during busy
    req(2'b01, 16'hF900, 8'hA5);
    req(2'b01, 16'hF901, 8'h5A);
    settle();
    rd_exp(16'hF900, 'hA5, "R8 first");
    rd_exp(16'hF901, 'hFF, "R8 ignored");

    // R6 erase disabled
    req(2'b10, 16'hF81F, 8'h00);
    chk("R6 no busy", busy, 0);
    rd_exp(16'hF805, 'h3C, "R6 kept");

    // R5 erase, low bits ignored
    erase_en = 1'b1;
    req(2'b10, 16'hF81F, 8'h00);
    begin
      int n = 0;
      while (busy) begin chk("R5 no stretch", stretch, 0); n++; @(negedge clk); end
      chk("R5 cycles", n, ERAS);
    end
    erase_en = 1'b0;
    rd_exp(16'hF805, 'hFF, "R5 erased a");
    rd_exp(16'hF81E, 'hFF, "R5 erased b");
    rd_exp(16'hF820, 'h12, "R5 next page kept");
    req(2'b01, 16'hF805, 8'h77); settle();
    rd_exp(16'hF805, 'h77, "R5 reprogram");

    // R7 outside window and reserved op
    req(2'b01, 16'hF7FF, 8'h01);
    chk("R7 low", busy, 0);
    req(2'b01, 16'hFC00, 8'h01);
    chk("R7 high", busy, 0);
    req(2'b00, 16'hFC00, 8'h00);
    chk("R7 no read", rd_valid, 0);
    req(2'b11, 16'hF810, 8'h01);
    chk("R7 op11", busy, 0);
    rd_exp(16'hF810, 'hFF, "R7 op11 unchanged");
    req(2'b01, 16'hFBFF, 8'h42); settle();
    rd_exp(16'hFBFF, 'h42, "R7 top byte");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule